// File: doc/BRIEF.md
# Scaled-Add Execution Unit

This block is a 64-bit integer execution unit for a small family of scaled-add operations. Each operation takes two register values, an addend source and a base, plus a 2-bit scale selector. The addend source is first widened in one of three ways: it is used as is, or its low 32 bits are sign-extended, or its low 32 bits are zero-extended. The widened value is then shifted left by the selector plus one and added to the base. The sum wraps modulo 2^64.

The unit decodes a 10-bit extended opcode field to choose the widening mode. A code that matches none of the three modes is flagged as illegal and produces no result. When the record bit is set, the unit also produces a 4-bit condition field: less-than, greater-than and equal compare the result with zero as a signed value, and the fourth bit copies the incoming summary-overflow bit. The result sits in one output register with a valid/ready handshake and a latency of one cycle.

Top module: `shift_add_unit`

## Requirements
- R1: With opcode bits [7:0] = 8'b01101110 (full mode), the result is ((opB << (shiftSel+1)) + opA) mod 2^64.
- R2: With opcode bits [7:0] = 8'b10101110 (signed-word mode), the addend is opB[31:0] with bits 63..32 all set to opB[31]. The result is that value shifted left by shiftSel+1, plus opA, mod 2^64.
- R3: With opcode bits [7:0] = 8'b11101110 (unsigned-word mode), the addend is opB[31:0] with bits 63..32 cleared. It is then shifted and added as in R2.
- R4: The shift distance is shiftSel+1 (1 to 4). Bits shifted past bit 63 are lost, zeros enter at bit 0, and the carry out of the add is dropped.
- R5: Opcode bits [9:8] have no effect on decoding or on the result.
- R6: An accepted operation whose opcode bits [7:0] match none of the three codes makes illegalOp high for exactly the one cycle after acceptance, and outValid stays low.
- R7: For an operation accepted with recordBit=1, crWrite is 1 and crField = {LT, GT, EQ, SO} (bit 3 down to bit 0). LT = result bit 63, EQ = (result == 0), GT = neither of those, and SO = soIn as sampled at acceptance.
- R8: For an operation accepted with recordBit=0, crWrite is 0 and crField keeps the value it had before.
- R9: An operation is accepted on a clock edge where inValid and inReady are both high, and its result appears with outValid on the next cycle. While outValid is high and outReady is low, the output is held and inReady is low.
- R10: After reset, outValid, illegalOp and crWrite are 0 and inReady is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operation is offered |
| inReady | output | 1 | The unit can take an operation |
| opXo | input | 10 | Extended opcode field |
| opA | input | 64 | Base addend |
| opB | input | 64 | Value that is widened and shifted |
| shiftSel | input | 2 | Scale selector; shift distance is this plus one |
| recordBit | input | 1 | Request a condition-field update |
| soIn | input | 1 | Incoming summary-overflow bit |
| outValid | output | 1 | Result is present |
| outReady | input | 1 | Consumer takes the result |
| result | output | 64 | Wrapped scaled sum |
| crField | output | 4 | Condition field {LT, GT, EQ, SO} |
| crWrite | output | 1 | Condition field is updated for this result |
| illegalOp | output | 1 | The last accepted opcode was not recognised |

## Verification
A fixed addend source with bit 31 set is run through signed-word mode at all four scale values. This separates sign extension from zero extension, and it shows where each shift distance drops high bits. Random operands cover every mode, every scale value and both record settings, with bit 31 forced both clear and set. The top opcode bits are also random, so a decoder that looks at them gives wrong results. Directed operands produce a zero sum, a wrapped sum and a negative sum, which exercise each condition bit in turn. Bursts with a stalled consumer show whether the output register holds and whether back-pressure reaches inReady.

// File: rtl/sa_pkg.sv
package sa_pkg;

  localparam int XoW = 10;
  localparam logic [7:0] XoFull  = 8'b01101110;
  localparam logic [7:0] XoSWord = 8'b10101110;
  localparam logic [7:0] XoUWord = 8'b11101110;

  typedef enum logic [1:0] {
    ExtFull  = 2'd0,
    ExtSWord = 2'd1,
    ExtUWord = 2'd2
  } ext_mode_e;

  typedef struct packed {
    logic      load;
    ext_mode_e mode;
    logic      record;
  } sa_strobe_t;

endpackage

// File: rtl/sa_ctrl.sv
module sa_ctrl
  import sa_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inValid,
  input  logic [XoW-1:0] opXo,
  input  logic           recordBit,
  input  logic           outReady,
  output logic           inReady,
  output logic           outValid,
  output logic           illegalOp,
  output sa_strobe_t     strobes
);

  logic      known;
  ext_mode_e mode;
  logic      accept;

  always_comb begin
    known = 1'b1;
    mode  = ExtFull;
    case (opXo[7:0])
      XoFull:  mode = ExtFull;
      XoSWord: mode = ExtSWord;
      XoUWord: mode = ExtUWord;
      default: known = 1'b0;
    endcase
  end

  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  assign strobes.load   = accept && known;
  assign strobes.mode   = mode;
  assign strobes.record = recordBit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      illegalOp <= accept && !known;
      if (accept)
        outValid <= known;
      else if (outReady)
        outValid <= 1'b0;
    end
  end

  // R6: an unknown code raises the flag and produces no result
  a_r6_illegal_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady && !known) |=> (illegalOp && !outValid));

  // R9: a held result stays valid until it is taken
  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid);

  // R9: a legal accept yields a result on the next cycle
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady && known) |=> (outValid && !illegalOp));

endmodule

// File: rtl/sa_datapath.sv
module sa_datapath
  import sa_pkg::*;
#(
  parameter int W   = 64,
  parameter int SHW = 2
)(
  input  logic           clk,
  input  logic           rst_n,
  input  sa_strobe_t     strobes,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  input  logic [SHW-1:0] shiftSel,
  input  logic           soIn,
  output logic [W-1:0]   result,
  output logic [3:0]     crField,
  output logic           crWrite
);

  localparam int Half = W / 2;
  localparam int NSh  = 1 << SHW;

  logic [W-1:0] extB;
  logic [W-1:0] shCand [NSh];
  logic [W-1:0] shifted;
  logic [W-1:0] sum;
  logic         isNeg;
  logic         isZero;
  logic [3:0]   crNext;

  always_comb begin
    case (strobes.mode)
      ExtSWord: extB = {{Half{opB[Half-1]}}, opB[Half-1:0]};
      ExtUWord: extB = {{Half{1'b0}}, opB[Half-1:0]};
      default:  extB = opB;
    endcase
  end

  for (genvar k = 0; k < NSh; k++) begin : g_shift
    assign shCand[k] = extB << (k + 1);
  end

  assign shifted = shCand[shiftSel];
  assign sum     = shifted + opA;
  assign isNeg   = sum[W-1];
  assign isZero  = (sum == '0);
  assign crNext  = {isNeg, !isNeg && !isZero, isZero, soIn};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      crField <= '0;
      crWrite <= 1'b0;
    end else if (strobes.load) begin
      result  <= sum;
      crWrite <= strobes.record;
      if (strobes.record)
        crField <= crNext;
    end
  end

  // R9: the output register changes only on a load
  a_r9_output_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.load |=> ($stable(result) && $stable(crField)));

  // R7: exactly one of LT, GT, EQ when the field is written
  a_r7_one_compare: assert property (@(posedge clk) disable iff (!rst_n)
    crWrite |-> ($countones(crField[3:1]) == 1));

  // R7: EQ agrees with a zero result
  a_r7_eq_zero: assert property (@(posedge clk) disable iff (!rst_n)
    crWrite |-> (crField[1] == (result == '0)));

  // R8: a non-recording load leaves the field alone
  a_r8_keep_field: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.load && !strobes.record) |=> $stable(crField));

endmodule

// File: rtl/shift_add_unit.sv
module shift_add_unit
  import sa_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output logic        inReady,
  input  logic [9:0]  opXo,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [1:0]  shiftSel,
  input  logic        recordBit,
  input  logic        soIn,
  output logic        outValid,
  input  logic        outReady,
  output logic [63:0] result,
  output logic [3:0]  crField,
  output logic        crWrite,
  output logic        illegalOp
);

  sa_strobe_t strobes;

  sa_ctrl uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .opXo      (opXo),
    .recordBit (recordBit),
    .outReady  (outReady),
    .inReady   (inReady),
    .outValid  (outValid),
    .illegalOp (illegalOp),
    .strobes   (strobes)
  );

  sa_datapath #(.W(64), .SHW(2)) uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .shiftSel (shiftSel),
    .soIn     (soIn),
    .result   (result),
    .crField  (crField),
    .crWrite  (crWrite)
  );

  // R9: back-pressure reaches the input side
  a_r9_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |-> !inReady);

endmodule

// File: tb/shift_add_unit_test.sv
module shift_add_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [9:0]  opXo = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [1:0]  shiftSel = '0;
  logic        recordBit = 1'b0;
  logic        soIn = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [63:0] result;
  logic [3:0]  crField;
  logic        crWrite;
  logic        illegalOp;

  int errors = 0;
  int checks = 0;
  bit stallMode = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    bit          bad;
    logic [63:0] res;
    logic [3:0]  cr;
    bit          crw;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  logic [3:0] lastCr = 4'h0;

  always #5 clk = ~clk;

  shift_add_unit uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .opXo(opXo), .opA(opA), .opB(opB), .shiftSel(shiftSel),
    .recordBit(recordBit), .soIn(soIn), .outValid(outValid),
    .outReady(outReady), .result(result), .crField(crField),
    .crWrite(crWrite), .illegalOp(illegalOp)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] widen(input logic [7:0] code, input logic [63:0] b);
    longint signed s;
    if (code == 8'b10101110) begin
      s = longint'(int'(b[31:0]));
      return 64'(s);
    end else if (code == 8'b11101110) begin
      return 64'(b[31:0]);
    end
    return b;
  endfunction

  task automatic send(input logic [9:0] xo, input logic [63:0] a, input logic [63:0] b,
                      input logic [1:0] sm, input bit rec, input bit so, input string tag);
    exp_t e;
    logic [127:0] wide;
    bit known;
    known = (xo[7:0] == 8'b01101110) || (xo[7:0] == 8'b10101110) || (xo[7:0] == 8'b11101110);
    wide = {64'd0, widen(xo[7:0], b)} << (int'(sm) + 1);
    e.bad = !known;
    e.res = wide[63:0] + a;
    e.crw = rec;
    e.tag = tag;
    if (known && rec)
      lastCr = {e.res[63], !e.res[63] && (e.res != 0), e.res == 0, so};
    e.cr = lastCr;
    @(negedge clk);
    inValid = 1'b1; opXo = xo; opA = a; opB = b; shiftSel = sm; recordBit = rec; soIn = so;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    expQ.push_back(e);
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  always @(negedge clk) begin
    outReady <= stallMode ? (($urandom % 3) != 0) : 1'b1;
  end

  always begin
    exp_t e;
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (illegalOp) begin
        if (expQ.size() == 0) check(1'b0, "R6 unexpected illegal flag", 1, 0);
        else begin
          e = expQ.pop_front();
          check(e.bad, "R6 illegal flag", 1, {63'd0, e.bad});
          check(!outValid, "R6 outValid with illegal", {63'd0, outValid}, 0);
        end
      end
      if (outValid && !outReady)
        check(!inReady, "R9 inReady during stall", {63'd0, inReady}, 0);
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(1'b0, "R9 result with nothing pending", result, 0);
        else begin
          e = expQ.pop_front();
          check(!e.bad, "R6 result for illegal op", result, 0);
          check(result == e.res, e.tag, result, e.res);
          check(crWrite == e.crw, e.crw ? "R7 crWrite" : "R8 crWrite", {63'd0, crWrite}, {63'd0, e.crw});
          check(crField == e.cr, e.crw ? "R7 crField" : "R8 crField kept", {60'd0, crField}, {60'd0, e.cr});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    logic [7:0] codes [3];
    codes[0] = 8'b01101110; codes[1] = 8'b10101110; codes[2] = 8'b11101110;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(!outValid, "R10 outValid", {63'd0, outValid}, 0);
    check(!illegalOp, "R10 illegalOp", {63'd0, illegalOp}, 0);
    check(!crWrite, "R10 crWrite", {63'd0, crWrite}, 0);
    check(inReady, "R10 inReady", {63'd0, inReady}, 1);
    rst_n = 1'b1;

    // R2: known vector, bit 31 set, every scale value
    for (int sm = 0; sm < 4; sm++)
      send({2'b00, 8'b10101110}, 64'hf00dcafedeadbeef, 64'habadbabedefec8ed, 2'(sm), 1'b1, 1'b0, "R2 known vector");
    // R3: same operand zero-extended
    for (int sm = 0; sm < 4; sm++)
      send({2'b00, 8'b11101110}, 64'hf00dcafedeadbeef, 64'habadbabedefec8ed, 2'(sm), 1'b0, 1'b0, "R3 unsigned word");
    // R1 and R4: top bits shifted out, wrap of the add
    send({2'b11, 8'b01101110}, 64'hffffffffffffffff, 64'hf000000000000001, 2'd3, 1'b1, 1'b1, "R4 shift drop and wrap");
    // R7: zero sum gives EQ
    send({2'b00, 8'b01101110}, 64'hfffffffffffffffe, 64'd1, 2'd0, 1'b1, 1'b0, "R7 zero sum");
    // R7: positive sum gives GT, SO copied
    send({2'b01, 8'b01101110}, 64'd5, 64'd3, 2'd1, 1'b1, 1'b1, "R7 positive sum");
    // R8: non-recording op keeps the field
    send({2'b10, 8'b10101110}, 64'd0, 64'h80000000, 2'd0, 1'b0, 1'b0, "R8 no record");
    // R6: unknown codes
    send({2'b00, 8'b00101110}, 64'd1, 64'd2, 2'd0, 1'b1, 1'b0, "R6 bad code");
    send({2'b11, 8'b11111111}, 64'd1, 64'd2, 2'd0, 1'b1, 1'b0, "R6 bad code");
    send({2'b00, 8'b11101110}, 64'd7, 64'd1, 2'd2, 1'b1, 1'b0, "R3 after illegal");

    // R5 and R9: random operands, random top bits, stalled consumer
    stallMode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      int m;
      m = i % 3;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      b[31] = i[3];
      send({2'($urandom), codes[m]}, a, b, 2'(i / 3), i[2], i[4],
           m == 0 ? "R1 R5 random full" : (m == 1 ? "R2 R5 random signed" : "R3 R5 random unsigned"));
      if (i % 37 == 0)
        send({2'($urandom), 8'b01010101}, a, b, 2'd1, 1'b1, 1'b0, "R6 random bad code");
    end
    stallMode = 1'b0;
    repeat (10) @(posedge clk);
    check(expQ.size() == 0, "R9 all results delivered", 64'(expQ.size()), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule